// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Guard

This block sits between a memory controller and a group of external static RAMs. It passes a set of active-low chip-enable strobes through to the memories while the supply is healthy. When a digital power-good flag from an external supply comparator drops, it blocks new memory cycles so that nothing gets written during the supply collapse. A strobe that is already active when the failure is seen may finish its cycle, but only within a bounded grace window. After that window it is cut off.

When power-good comes back, every output stays parked high for a recovery interval before normal pass-through resumes. Coming out of reset, the block behaves as though the supply has not yet been good. All timing is counted in clock cycles and set by parameters. Both the failure detection and the release happen on clock edges. During pass-through, the path from each input to its output is purely combinational.

Top module: `pf_ce_guard`

## Requirements
- R1: While the guard is in normal operation, every `ce_out_n` bit equals the matching `ce_in_n` bit in the same cycle, for both the high and the low level.
- R2: The first rising clock edge that samples `pwr_good` low during normal operation is the detection edge. Every lane whose `ce_in_n` is high at that edge is forced high from that edge on.
- R3: A lane whose `ce_in_n` is low at the detection edge keeps following its input. At the first edge where that input is high, the lane is forced high, and it stays high even if the input drops low again before release.
- R4: A lane still low under grace is forced high at the GRACE_CYC-th rising edge after the detection edge, whatever its input is. An access can therefore remain low for at most GRACE_CYC cycles after detection.
- R5: Recovery starts at the first edge that samples `pwr_good` high while no lane is under grace. All lanes stay forced high through that edge and the next RECOVER_CYC edges. Pass-through resumes after the RECOVER_CYC-th edge following the start.
- R6: If `pwr_good` is sampled low at any edge during recovery, the guard returns to the failed state with all lanes still forced high, and a later recovery counts its full interval again.
- R7: While `rst_n` is low, all `ce_out_n` bits and `protect_o` are high. After reset, the guard starts in the failed state with no lane under grace.
- R8: `protect_o` is high exactly when at least one lane is being forced high. When it is low, `ce_out_n` equals `ce_in_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-healthy flag from the external comparator, high when healthy |
| ce_in_n | input | NUM_CH | Active-low chip-enable strobes from the controller |
| ce_out_n | output | NUM_CH | Guarded active-low chip enables to the memories |
| protect_o | output | 1 | High while any lane is forced high |

## Verification
The bench builds the guard with four lanes, a grace window of 5 cycles and a recovery interval of 12 cycles. With these small values, the grace cut-off, the exact release edge and a power bounce in the middle of recovery all occur many times within a few thousand cycles. Random strobe patterns mixed with random power drops push lanes into all three exits from a failure: idle lanes blocked at detection, accesses that finish early, and accesses cut off by the timer. Directed episodes cover re-activating a lane after it has latched, and a failure while a grace lane is still open when power returns.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_FAIL    = 2'd1,
    PH_RECOVER = 2'd2
  } phase_e;

  // bits needed to count up to the larger of two cycle limits
  function automatic int cnt_bits(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction

  // true on the cycle that closes a window of len edges counted from 0
  function automatic bit at_last(int cnt, int len);
    return cnt == len - 1;
  endfunction

  // saturating increment
  function automatic int sat_inc(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/pfg_phase.sv
module pfg_phase
  import pfg_pkg::*;
#(
  parameter int GRACE_CYC   = 5,
  parameter int RECOVER_CYC = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_good,
  input  logic   any_grace,
  output phase_e phase,
  output logic   fail_evt,
  output logic   expire_evt,
  output logic   release_evt
);

  localparam int CW      = cnt_bits(GRACE_CYC, RECOVER_CYC);
  localparam int CNT_MAX = (1 << CW) - 1;

  logic [CW-1:0] cnt;

  assign fail_evt    = (phase == PH_RUN) && !pwr_good;
  assign expire_evt  = (phase == PH_FAIL) && at_last(int'(cnt), GRACE_CYC);
  assign release_evt = (phase == PH_RECOVER) && pwr_good &&
                       at_last(int'(cnt), RECOVER_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FAIL;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (!pwr_good) begin
            phase <= PH_FAIL;
            cnt   <= '0;
          end
        end
        PH_FAIL: begin
          if (pwr_good && !any_grace) begin
            phase <= PH_RECOVER;
            cnt   <= '0;
          end else begin
            cnt <= CW'(sat_inc(int'(cnt), CNT_MAX));
          end
        end
        PH_RECOVER: begin
          if (!pwr_good) begin
            phase <= PH_FAIL;
            cnt   <= '0;
          end else if (release_evt) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= CW'(sat_inc(int'(cnt), CNT_MAX));
          end
        end
        default: begin
          phase <= PH_FAIL;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pfg_lane.sv
module pfg_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic fail_evt,
  input  logic expire_evt,
  input  logic release_evt,
  output logic ce_out_n,
  output logic blocked,
  output logic in_grace
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked  <= 1'b1;
      in_grace <= 1'b0;
    end else if (release_evt) begin
      blocked  <= 1'b0;
      in_grace <= 1'b0;
    end else if (fail_evt) begin
      blocked  <= ce_in_n;
      in_grace <= !ce_in_n;
    end else if (in_grace && (ce_in_n || expire_evt)) begin
      blocked  <= 1'b1;
      in_grace <= 1'b0;
    end
  end

  assign ce_out_n = ce_in_n | blocked;

endmodule

// File: rtl/pf_ce_guard.sv
module pf_ce_guard
  import pfg_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int GRACE_CYC   = 5,
  parameter int RECOVER_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [NUM_CH-1:0] ce_in_n,
  output logic [NUM_CH-1:0] ce_out_n,
  output logic              protect_o
);

  phase_e            phase;
  logic              fail_evt;
  logic              expire_evt;
  logic              release_evt;
  logic              any_grace;
  logic              in_run;
  logic              in_recover;
  logic [NUM_CH-1:0] lane_blk;
  logic [NUM_CH-1:0] lane_grace;

  pfg_phase #(
    .GRACE_CYC  (GRACE_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .any_grace  (any_grace),
    .phase      (phase),
    .fail_evt   (fail_evt),
    .expire_evt (expire_evt),
    .release_evt(release_evt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    pfg_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_in_n    (ce_in_n[g]),
      .fail_evt   (fail_evt),
      .expire_evt (expire_evt),
      .release_evt(release_evt),
      .ce_out_n   (ce_out_n[g]),
      .blocked    (lane_blk[g]),
      .in_grace   (lane_grace[g])
    );
  end

  assign any_grace  = |lane_grace;
  assign protect_o  = |lane_blk;
  assign in_run     = (phase == PH_RUN);
  assign in_recover = (phase == PH_RECOVER);

endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
  parameter int NUM_CH      = 4,
  parameter int GRACE_CYC   = 5,
  parameter int RECOVER_CYC = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ce_in_n,
  input logic [NUM_CH-1:0] ce_out_n,
  input logic              protect_o,
  input logic              fail_evt,
  input logic              release_evt,
  input logic              in_run,
  input logic              in_recover,
  input logic [NUM_CH-1:0] blk,
  input logic [NUM_CH-1:0] grace
);

  localparam int GW = $clog2(GRACE_CYC + 1);
  localparam int RW = $clog2(RECOVER_CYC + 1);

  logic [GW-1:0] ecnt;
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= GW'(GRACE_CYC);
    end else if (fail_evt) begin
      ecnt <= '0;
    end else if (ecnt != GW'(GRACE_CYC)) begin
      ecnt <= ecnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
    end else if (!in_recover) begin
      rcnt <= '0;
    end else if (rcnt != RW'(RECOVER_CYC)) begin
      rcnt <= rcnt + 1'b1;
    end
  end

  a_r1_follow_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (ce_out_n == ce_in_n));

  a_r2_idle_lanes_locked: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> ((blk & $past(ce_in_n)) == $past(ce_in_n)));

  a_r3_no_unlock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(blk) & ~blk)) |-> $past(release_evt));

  a_r3_grace_lane_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|grace) |-> ((ce_out_n & grace) == (ce_in_n & grace)));

  a_r4_grace_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (|grace) |-> (ecnt < GW'(GRACE_CYC)));

  a_r5_release_window: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |-> (rcnt == RW'(RECOVER_CYC - 1)));

  a_r5_recover_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_recover |-> (&ce_out_n));

  a_r8_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !protect_o |-> (ce_out_n == ce_in_n));

endmodule

bind pf_ce_guard pfg_chk #(
  .NUM_CH     (NUM_CH),
  .GRACE_CYC  (GRACE_CYC),
  .RECOVER_CYC(RECOVER_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_in_n    (ce_in_n),
  .ce_out_n   (ce_out_n),
  .protect_o  (protect_o),
  .fail_evt   (fail_evt),
  .release_evt(release_evt),
  .in_run     (in_run),
  .in_recover (in_recover),
  .blk        (lane_blk),
  .grace      (lane_grace)
);

// File: tb/sim_pf_ce_guard.sv
`timescale 1ns/1ps
module sim_pf_ce_guard;

  localparam int N = 4;
  localparam int G = 5;
  localparam int R = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_good = 1'b0;
  logic [N-1:0] ce_in_n = '1;
  logic [N-1:0] ce_out_n;
  logic         protect_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pf_ce_guard #(.NUM_CH(N), .GRACE_CYC(G), .RECOVER_CYC(R)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .ce_in_n(ce_in_n), .ce_out_n(ce_out_n), .protect_o(protect_o)
  );

  // reference model: 0 normal, 1 down, 2 coming back up
  int     m_mode = 1;
  int     m_tick = 0;
  bit     m_hold [N];
  bit     m_pend [N];

  initial for (int i = 0; i < N; i++) begin m_hold[i] = 1; m_pend[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 1;
      m_tick = 0;
      for (int i = 0; i < N; i++) begin m_hold[i] = 1; m_pend[i] = 0; end
    end else begin
      case (m_mode)
        0: if (!pwr_good) begin
             m_mode = 1;
             m_tick = 0;
             for (int i = 0; i < N; i++) begin
               if (ce_in_n[i]) m_hold[i] = 1; else m_pend[i] = 1;
             end
           end
        1: begin
             bit open_any;
             open_any = 0;
             for (int i = 0; i < N; i++) open_any |= m_pend[i];
             m_tick++;
             for (int i = 0; i < N; i++)
               if (m_pend[i] && (ce_in_n[i] || m_tick >= G)) begin
                 m_pend[i] = 0;
                 m_hold[i] = 1;
               end
             if (pwr_good && !open_any) begin
               m_mode = 2;
               m_tick = 0;
             end
           end
        default: if (!pwr_good) begin
             m_mode = 1;
             m_tick = 0;
           end else begin
             m_tick++;
             if (m_tick == R) begin
               m_mode = 0;
               for (int i = 0; i < N; i++) m_hold[i] = 0;
             end
           end
      endcase
    end
  end

  function automatic string ctx_tag(int i);
    if (!rst_n) return "R7";
    if (m_mode == 0) return "R1";
    if (m_mode == 2) return "R5";
    if (m_pend[i]) return "R3";
    return "R2";
  endfunction

  task automatic check_all(string tag);
    bit any_hold;
    any_hold = !rst_n;
    for (int i = 0; i < N; i++) begin
      bit exp;
      string t;
      exp = ce_in_n[i] | m_hold[i] | !rst_n;
      any_hold |= m_hold[i];
      t = (tag != "") ? tag : ctx_tag(i);
      checks++;
      if (ce_out_n[i] !== exp) begin
        failures++;
        $display("FAIL %s lane %0d ce_out_n=%b expected %b", t, i, ce_out_n[i], exp);
      end
    end
    checks++;
    if (protect_o !== any_hold) begin
      failures++;
      $display("FAIL R8 protect_o=%b expected %b", protect_o, any_hold);
    end
  endtask

  task automatic step(bit pg, logic [N-1:0] ce, string tag);
    @(negedge clk);
    pwr_good = pg;
    ce_in_n  = ce;
    #1;
    check_all(tag);
  endtask

  bit done = 0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ce;
    bit pg;
    // R7: reset state with active inputs and either power level
    for (int k = 0; k < 3; k++) step(1'b0, 4'b0000, "R7");
    for (int k = 0; k < 2; k++) step(1'b1, 4'b0000, "R7");
    @(negedge clk); rst_n = 1'b1;
    // R5: power-up recovery, inputs active throughout
    for (int k = 0; k < R + 4; k++) step(1'b1, 4'b0000, "");
    // R1: pass-through patterns
    step(1'b1, 4'b1010, "R1");
    step(1'b1, 4'b0101, "R1");
    step(1'b1, 4'b1110, "R1");
    // R4: lane 0 held low past the grace window; R2 for the others
    step(1'b0, 4'b1110, "");
    for (int k = 0; k < G + 2; k++) step(1'b0, 4'b1110, (k >= G - 1) ? "R4" : "");
    for (int k = 0; k < R + 3; k++) step(1'b1, 4'b1111, "");
    // R3: lane 1 finishes early, then tries to go low again
    step(1'b1, 4'b1101, "R1");
    step(1'b0, 4'b1101, "");
    step(1'b0, 4'b1101, "R3");
    step(1'b0, 4'b1111, "R3");
    for (int k = 0; k < 4; k++) step(1'b0, 4'b1101, "R3");
    // R6: power bounce during recovery
    for (int k = 0; k < 5; k++) step(1'b1, 4'b0000, "R6");
    for (int k = 0; k < 2; k++) step(1'b0, 4'b0000, "R6");
    for (int k = 0; k < R + 3; k++) step(1'b1, 4'b0000, (k < R) ? "R6" : "");
    // power returns while a lane is still in its grace window
    step(1'b1, 4'b0111, "R1");
    step(1'b0, 4'b0111, "");
    for (int k = 0; k < G + R + 3; k++) step(1'b1, 4'b0111, "");
    // random mix
    void'($urandom(32'h5eed_1234));
    pg = 1'b1;
    ce = '1;
    for (int k = 0; k < 6000; k++) begin
      if (pg && ($urandom % 40) == 0) pg = 1'b0;
      else if (!pg && ($urandom % 6) == 0) pg = 1'b1;
      for (int i = 0; i < N; i++)
        if (($urandom % 4) == 0) ce[i] = ~ce[i];
      step(pg, ce, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule